// File: doc/BRIEF.md
# Instruction Sequencer and Control Unit

This block sequences a small processor that runs 12-bit instructions. It keeps a 3-bit program counter, a 12-bit instruction register and an eight-word program store. Each debounced step pulse runs one instruction through three clocked phases: capture, decode and one execute cycle whose state is chosen by the opcode. In the execute cycle the unit drives enables and addresses to the register file, data memory, ALU and sort/display engine, which sit outside this block.

An instruction can come from the program store at the program counter or, when the external flag is set, straight from the 12 switch bits. An external instruction leaves the program counter where it was. A separate append pulse writes the switch word into the program store at a tail pointer and then advances that pointer, so a program can be extended while it runs. A synchronous clear puts the sequencer back to its waiting state.

Top module: `seq_ctrl`

## Requirements
- R1: The opcode is instruction bits [11:9]. The codes are 0 load, 1 store, 2 sub, 3 add, 4 ascending sort, 5 descending sort and 6 display. In the execute cycle only that opcode's enables are high. In the capture wait and in the decode cycle all enables are low.
- R2: In the load execute cycle, dm_re=1, rf_we=1, dm_we=0 and wb_alu=0. dm_addr carries bits [3:0] and rf_wa carries bits [6:4]. Bits [8:7] have no effect.
- R3: In the store execute cycle, dm_we=1, dm_re=0 and rf_we=0. dm_addr carries bits [3:0] and rf_ra1 carries bits [6:4].
- R4: In the sub and add execute cycles, rf_we=1 and wb_alu=1. rf_wa carries bits [8:6], rf_ra1 carries bits [5:3] and rf_ra2 carries bits [2:0]. alu_sub is 1 for sub and 0 for add.
- R5: Opcodes 4 and 5 raise sort_go for their execute cycle, with sort_desc equal to 1 only for opcode 5. Opcode 6 raises disp_go.
- R6: idle is high while the unit waits, and the unit waits until a step pulse arrives. A step accepted at edge k gives the decode cycle after k and the execute cycle after k+1, and idle is high again after k+2. A step seen outside the wait state has no effect.
- R7: A step with ext=0 loads the program word at the program counter into the instruction register and increments the program counter modulo 8.
- R8: A step with ext=1 loads the switch bits into the instruction register and leaves the program counter unchanged.
- R9: An append pulse stores the switch word at the tail pointer and advances the pointer modulo 8. When an append and a program capture hit the same slot in one cycle, the capture gets the word held before the write.
- R10: Opcode 7 is a no-op. After its decode cycle the unit returns straight to waiting, and no enable is raised.
- R11: clear has priority over every other input. It sets the program counter, instruction register and tail pointer to 0 and returns the unit to waiting. An append during clear is dropped, and the program store keeps its contents.
- R12: f_op, f_dst, f_src and f_cnt always show instruction register bits [11:9], [8:6], [5:3] and [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear |
| step | input | 1 | Debounced pulse that runs one instruction |
| ext | input | 1 | Take the instruction from the switches |
| sw | input | 12 | Switch instruction word |
| append | input | 1 | Append the switch word to the program store |
| pc | output | 3 | Program counter |
| ir | output | 12 | Instruction register |
| idle | output | 1 | Waiting for a step |
| dm_addr | output | 4 | Data memory address |
| dm_re | output | 1 | Data memory read enable |
| dm_we | output | 1 | Data memory write enable |
| rf_we | output | 1 | Register file write enable |
| rf_wa | output | 3 | Register file write address |
| rf_ra1 | output | 3 | Register file first read address |
| rf_ra2 | output | 3 | Register file second read address |
| wb_alu | output | 1 | Write back the ALU result rather than memory data |
| alu_sub | output | 1 | ALU subtracts |
| sort_go | output | 1 | Start the sort engine |
| sort_desc | output | 1 | Sort in descending order |
| disp_go | output | 1 | Start the display sequence |
| f_op | output | 3 | Opcode field |
| f_dst | output | 3 | Destination field |
| f_src | output | 3 | Source field |
| f_cnt | output | 3 | Count / second operand field |

## Verification
An append and a program capture can fall on the same clock edge. Their collision on one slot is the case that matters. The bench parks the tail pointer on the slot the program counter points to, then drives step and append together. It checks that the captured word is the one held before the write, and that a later pass over that slot returns the new word. A clear that arrives together with an append in the middle of an instruction is also driven. It is judged by checking that the next append lands in slot 0 and that the other slots kept their words.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

   localparam int OPW = 3;

   typedef enum logic [3:0] {
      ST_WAIT, ST_DECODE, ST_LOAD, ST_STORE, ST_SUB, ST_ADD,
      ST_ASC, ST_DES, ST_DISP
   } seq_state_e;

   // opcode to execute state; the unused code returns to waiting
   function automatic seq_state_e op_to_state(input logic [OPW-1:0] op);
      case (op)
         3'd0:    return ST_LOAD;
         3'd1:    return ST_STORE;
         3'd2:    return ST_SUB;
         3'd3:    return ST_ADD;
         3'd4:    return ST_ASC;
         3'd5:    return ST_DES;
         3'd6:    return ST_DISP;
         default: return ST_WAIT;
      endcase
   endfunction

endpackage

// File: rtl/imem_queue.sv
module imem_queue #(
   parameter int IW = 12,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [IW-1:0] rd_data,
   output logic [AW-1:0] tail
);
   localparam int DEPTH = 1 << AW;

   logic [IW-1:0] words [DEPTH];
   logic          wr_ok;

   assign wr_ok = wr_en && !clr;

   always_ff @(posedge clk) begin
      if (clr)        tail <= '0;
      else if (wr_en) tail <= tail + 1'b1;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [IW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (wr_ok && tail == AW'(i)) slot_q <= wr_data;
      end
      assign words[i] = slot_q;
   end

   // read returns the word held before any write on the same edge
   assign rd_data = words[rd_addr];

   AST_TAIL_ADV: assert property (@(posedge clk) disable iff (clr)
      wr_en |=> tail == AW'($past(tail) + 1'b1)); // R9

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import seqctl_pkg::*;
#(
   parameter int IW = 12,
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          step,
   input  logic          ext,
   input  logic [IW-1:0] sw,
   input  logic [IW-1:0] mem_word,
   output logic [AW-1:0] pc,
   output logic [IW-1:0] ir,
   output seq_state_e    state
);
   logic take, pc_we;

   assign take  = (state == ST_WAIT) && step;
   assign pc_we = take && !ext;

   always_ff @(posedge clk) begin
      if (clr) begin
         state <= ST_WAIT;
         pc    <= '0;
         ir    <= '0;
      end else begin
         if (take) ir <= ext ? sw : mem_word;
         if (pc_we) pc <= pc + 1'b1;
         case (state)
            ST_WAIT:   if (step) state <= ST_DECODE;
            ST_DECODE: state <= op_to_state(ir[IW-1 -: OPW]);
            default:   state <= ST_WAIT;
         endcase
      end
   end

   AST_PC_ADV: assert property (@(posedge clk) disable iff (clr)
      (state == ST_WAIT && step && !ext) |=> pc == AW'($past(pc) + 1'b1)); // R7
   AST_PC_EXT_HOLD: assert property (@(posedge clk) disable iff (clr)
      (state == ST_WAIT && step && ext) |=> $stable(pc)); // R8
   AST_IR_HOLD: assert property (@(posedge clk) disable iff (clr)
      (state != ST_WAIT) |=> $stable(ir) && $stable(pc)); // R6
   AST_DECODE_ONCE: assert property (@(posedge clk) disable iff (clr)
      (state == ST_DECODE) |=> state != ST_DECODE); // R6
   AST_EXEC_RETURN: assert property (@(posedge clk) disable iff (clr)
      (state != ST_WAIT && state != ST_DECODE) |=> state == ST_WAIT); // R6

endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
   import seqctl_pkg::*;
#(
   parameter int DAW = 4,
   parameter int RAW = 3,
   localparam int LW = (3 * RAW > DAW + RAW) ? 3 * RAW : DAW + RAW
) (
   input  seq_state_e     state,
   input  logic [LW-1:0]  low,
   output logic [DAW-1:0] dm_addr,
   output logic           dm_re,
   output logic           dm_we,
   output logic           rf_we,
   output logic [RAW-1:0] rf_wa,
   output logic [RAW-1:0] rf_ra1,
   output logic [RAW-1:0] rf_ra2,
   output logic           wb_alu,
   output logic           alu_sub,
   output logic           sort_go,
   output logic           sort_desc,
   output logic           disp_go
);
   logic mem_op;

   assign mem_op  = (state == ST_LOAD) || (state == ST_STORE);
   assign dm_addr = low[DAW-1:0];
   assign rf_ra2  = low[RAW-1:0];
   assign rf_ra1  = mem_op ? low[DAW +: RAW] : low[RAW +: RAW];
   assign rf_wa   = mem_op ? low[DAW +: RAW] : low[2*RAW +: RAW];

   always_comb begin
      dm_re = 1'b0; dm_we = 1'b0; rf_we = 1'b0; wb_alu = 1'b0;
      alu_sub = 1'b0; sort_go = 1'b0; sort_desc = 1'b0; disp_go = 1'b0;
      case (state)
         ST_LOAD:  begin dm_re = 1'b1; rf_we = 1'b1; end
         ST_STORE: dm_we = 1'b1;
         ST_SUB:   begin rf_we = 1'b1; wb_alu = 1'b1; alu_sub = 1'b1; end
         ST_ADD:   begin rf_we = 1'b1; wb_alu = 1'b1; end
         ST_ASC:   sort_go = 1'b1;
         ST_DES:   begin sort_go = 1'b1; sort_desc = 1'b1; end
         ST_DISP:  disp_go = 1'b1;
         default:  ;
      endcase
   end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seqctl_pkg::*;
#(
   parameter int IW  = 12,
   parameter int AW  = 3,
   parameter int DAW = 4,
   parameter int RAW = 3
) (
   input  logic           clk,
   input  logic           clr,
   input  logic           step,
   input  logic           ext,
   input  logic [IW-1:0]  sw,
   input  logic           append,
   output logic [AW-1:0]  pc,
   output logic [IW-1:0]  ir,
   output logic           idle,
   output logic [DAW-1:0] dm_addr,
   output logic           dm_re,
   output logic           dm_we,
   output logic           rf_we,
   output logic [RAW-1:0] rf_wa,
   output logic [RAW-1:0] rf_ra1,
   output logic [RAW-1:0] rf_ra2,
   output logic           wb_alu,
   output logic           alu_sub,
   output logic           sort_go,
   output logic           sort_desc,
   output logic           disp_go,
   output logic [OPW-1:0] f_op,
   output logic [RAW-1:0] f_dst,
   output logic [RAW-1:0] f_src,
   output logic [RAW-1:0] f_cnt
);
   localparam int LW = (3 * RAW > DAW + RAW) ? 3 * RAW : DAW + RAW;

   if (IW < OPW + LW) begin : g_bad_width
      $error("seq_ctrl: IW too small for opcode and operand fields");
   end
   if (AW < 1 || AW > 6) begin : g_bad_depth
      $error("seq_ctrl: AW out of range");
   end

   seq_state_e    state;
   logic [IW-1:0] mem_word;
   logic [AW-1:0] tail;

   imem_queue #(.IW(IW), .AW(AW)) u_store (
      .clk(clk), .clr(clr), .wr_en(append), .wr_data(sw),
      .rd_addr(pc), .rd_data(mem_word), .tail(tail)
   );

   seq_fsm #(.IW(IW), .AW(AW)) u_fsm (
      .clk(clk), .clr(clr), .step(step), .ext(ext), .sw(sw),
      .mem_word(mem_word), .pc(pc), .ir(ir), .state(state)
   );

   ctl_decode #(.DAW(DAW), .RAW(RAW)) u_dec (
      .state(state), .low(ir[LW-1:0]),
      .dm_addr(dm_addr), .dm_re(dm_re), .dm_we(dm_we), .rf_we(rf_we),
      .rf_wa(rf_wa), .rf_ra1(rf_ra1), .rf_ra2(rf_ra2), .wb_alu(wb_alu),
      .alu_sub(alu_sub), .sort_go(sort_go), .sort_desc(sort_desc),
      .disp_go(disp_go)
   );

   assign idle  = (state == ST_WAIT);
   assign f_op  = ir[IW-1 -: OPW];
   assign f_dst = ir[2*RAW +: RAW];
   assign f_src = ir[RAW +: RAW];
   assign f_cnt = ir[RAW-1:0];

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (clr)
      $onehot0({dm_we, rf_we, sort_go, disp_go})); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (clr)
      idle |-> !(dm_re || dm_we || rf_we || sort_go || disp_go)); // R1
   AST_NOP_SKIP: assert property (@(posedge clk) disable iff (clr)
      (state == ST_DECODE && f_op == 3'd7) |=> idle); // R10

endmodule

// File: tb/seq_ctrl_test.sv
module seq_ctrl_test;
   localparam int CLK_PER = 10;

   logic clk = 1'b0;
   always #(CLK_PER/2) clk = ~clk;

   logic clr = 1'b1, step = 1'b0, ext = 1'b0, append = 1'b0;
   logic [11:0] sw = '0;
   logic [2:0] pc, rf_wa, rf_ra1, rf_ra2, f_op, f_dst, f_src, f_cnt;
   logic [11:0] ir;
   logic [3:0] dm_addr;
   logic idle, dm_re, dm_we, rf_we, wb_alu, alu_sub, sort_go, sort_desc, disp_go;

   seq_ctrl uut (
      .clk(clk), .clr(clr), .step(step), .ext(ext), .sw(sw), .append(append),
      .pc(pc), .ir(ir), .idle(idle), .dm_addr(dm_addr), .dm_re(dm_re),
      .dm_we(dm_we), .rf_we(rf_we), .rf_wa(rf_wa), .rf_ra1(rf_ra1),
      .rf_ra2(rf_ra2), .wb_alu(wb_alu), .alu_sub(alu_sub), .sort_go(sort_go),
      .sort_desc(sort_desc), .disp_go(disp_go), .f_op(f_op), .f_dst(f_dst),
      .f_src(f_src), .f_cnt(f_cnt)
   );

   int total = 0, bad = 0;
   bit done = 0;
   logic [11:0] m_mem [8];
   logic [2:0]  m_pc = '0, m_tail = '0;
   logic [11:0] m_ir = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // {dm_re, dm_we, rf_we, wb_alu, alu_sub, sort_go, sort_desc, disp_go}
   function automatic logic [7:0] exp_en(input logic [2:0] op);
      case (op)
         3'd0: return 8'b1010_0000;
         3'd1: return 8'b0100_0000;
         3'd2: return 8'b0011_1000;
         3'd3: return 8'b0011_0000;
         3'd4: return 8'b0000_0100;
         3'd5: return 8'b0000_0110;
         3'd6: return 8'b0000_0001;
         default: return 8'b0;
      endcase
   endfunction

   function automatic logic [7:0] got_en();
      return {dm_re, dm_we, rf_we, wb_alu, alu_sub, sort_go, sort_desc, disp_go};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic do_append(input logic [11:0] w);
      @(negedge clk);
      sw = w; append = 1'b1;
      m_mem[m_tail] = w; m_tail = m_tail + 3'd1;
      @(negedge clk);
      append = 1'b0;
      chk("R6 append alone keeps idle", {31'd0, idle}, 32'd1);
   endtask

   task automatic run(input bit x, input logic [11:0] w, input bit app, input bit hold);
      logic [2:0] op;
      @(negedge clk);
      step = 1'b1; ext = x; sw = w; append = app;
      m_ir = x ? w : m_mem[m_pc];
      if (app) begin m_mem[m_tail] = w; m_tail = m_tail + 3'd1; end
      if (!x) m_pc = m_pc + 3'd1;
      op = m_ir[11:9];
      @(negedge clk);
      step = hold; ext = 1'b0; append = 1'b0;
      chk(x ? "R8 ir from switches" : "R7/R9 ir from store", {20'd0, ir}, {20'd0, m_ir});
      chk(x ? "R8 pc held" : "R7 pc advanced", {29'd0, pc}, {29'd0, m_pc});
      chk("R6 decode cycle quiet", {23'd0, idle, got_en()}, 32'd0);
      chk("R12 fields", {20'd0, f_op, f_dst, f_src, f_cnt}, {20'd0, m_ir});
      @(negedge clk);
      step = 1'b0;
      if (op == 3'd7) begin
         chk("R10 nop back to idle quietly", {23'd0, idle, got_en()}, 32'h100);
      end else begin
         chk("R1 execute enables", {23'd0, idle, got_en()}, {24'd0, exp_en(op)});
         if (op == 3'd0) begin
            chk("R2 load addresses", {25'd0, dm_addr, rf_wa}, {25'd0, m_ir[3:0], m_ir[6:4]});
         end else if (op == 3'd1) begin
            chk("R3 store addresses", {25'd0, dm_addr, rf_ra1}, {25'd0, m_ir[3:0], m_ir[6:4]});
         end else if (op == 3'd2 || op == 3'd3) begin
            chk("R4 alu addresses", {23'd0, rf_wa, rf_ra1, rf_ra2}, {23'd0, m_ir[8:0]});
         end else begin
            chk("R5 sort/display enables", {29'd0, sort_go, sort_desc, disp_go},
                {29'd0, exp_en(op)[2:0]});
         end
         @(negedge clk);
         chk("R6 idle after execute", {31'd0, idle}, 32'd1);
         chk("R6 late step ignored", {29'd0, pc}, {29'd0, m_pc});
      end
   endtask

   initial begin
      #(CLK_PER * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20251));
      @(negedge clk); @(negedge clk);
      clr = 1'b0;
      chk("R11 reset pc", {29'd0, pc}, 32'd0);
      chk("R11 reset ir", {20'd0, ir}, 32'd0);
      chk("R11 reset idle and quiet", {23'd0, idle, got_en()}, 32'h100);

      // R6: no step, stays waiting
      @(negedge clk); @(negedge clk);
      chk("R6 waits without step", {28'd0, idle, pc}, 32'h8);

      // fill store with every opcode; bits [8:7] set on the load to show they are ignored
      do_append(12'b000_11_101_1010);
      do_append(12'b001_10_011_0110);
      do_append(12'b010_101_011_001);
      do_append(12'b011_010_000_111);
      do_append(12'b100_000_010_100);
      do_append(12'b101_110_100_110);
      do_append(12'b110_000_011_101);
      do_append(12'b111_001_010_011);
      for (int i = 0; i < 8; i++) run(1'b0, 12'h000, 1'b0, i == 2);
      chk("R7 pc wrapped to 0", {29'd0, pc}, 32'd0);

      // external instruction, pc held
      run(1'b1, 12'b011_001_010_011, 1'b0, 1'b0);
      run(1'b1, 12'b111_000_000_000, 1'b0, 1'b0);

      // R9 collision: tail at 0, pc at 0, append and step same edge
      run(1'b0, 12'b101_011_001_010, 1'b1, 1'b0);
      for (int i = 0; i < 7; i++) run(1'b0, 12'h000, 1'b0, 1'b0);
      run(1'b0, 12'h000, 1'b0, 1'b0);  // slot 0 now holds the appended word

      // random mix
      for (int i = 0; i < 300; i++) begin
         int unsigned c;
         logic [11:0] w;
         c = $urandom_range(0, 5);
         w = 12'($urandom);
         case (c)
            0: do_append(w);
            1, 2: run(1'b0, w, 1'b0, 1'($urandom_range(0, 1)));
            3: run(1'b0, w, 1'b1, 1'b0);
            default: run(1'b1, w, 1'($urandom_range(0, 1)), 1'b0);
         endcase
      end

      // R11 clear mid-instruction with an append
      @(negedge clk);
      step = 1'b1; ext = 1'b0;
      @(negedge clk);
      step = 1'b0; clr = 1'b1; append = 1'b1; sw = 12'hABC;
      @(negedge clk);
      clr = 1'b0; append = 1'b0;
      m_pc = '0; m_tail = '0; m_ir = '0;
      chk("R11 clear pc/ir/idle", {16'd0, pc, ir, idle}, {16'd0, 3'd0, 12'd0, 1'b1});
      chk("R11 clear quiet", {24'd0, got_en()}, 32'd0);
      do_append(12'b011_100_101_110);
      run(1'b0, 12'h000, 1'b0, 1'b0);   // tail restarted at slot 0
      run(1'b0, 12'h000, 1'b0, 1'b0);   // slot 1 kept its word
      finish_run();
   end
endmodule